// File: doc/BRIEF.md
# SPI Flash Clock and Select Sequencer

This block is the timing core of a single-slave, quad-capable SPI flash master. Once enabled, it accepts a request to run a given number of SCLK pulses. It asserts the slave select and waits a programmed setup time. It then produces the pulses, each with a low phase and a high phase whose lengths are programmable in system clocks. After the last pulse it releases select and holds it inactive for a programmed minimum time, then reports completion with a one-cycle done pulse. Only SPI modes 0 and 3 are supported, so each pulse is always a low phase followed by a high phase, and input data is nominally captured at every rising SCLK edge.

Around this pulse engine sit several pin-level features. A capture strobe can be pushed up to 15 system clocks past each rising edge, so that slow board paths can be absorbed. In mode 3, a trailing low pulse can be added or suppressed before select is released. A pre-select drive places programmed values on the SDIO pins ahead of select and disarms itself at the next select assertion. A bit-bang mode hands all pins to software and gives the input levels back. Dropping the enable returns the engine to its idle state at once.

Top module: `flash_sclk_sequencer`

## Requirements
- R1: While a transaction is active, select is asserted from the cycle after the request is accepted until its last clock phase ends. The `ss` pin is low for an asserted select when `cfg_sel_act_high`=0, and high when it is 1.
- R2: Each SCLK low phase lasts `cfg_lo_code` system clocks and each high phase lasts `cfg_hi_code` system clocks, where code 0 means 16.
- R3: Between select assertion and the first SCLK low phase, select setup code 0/1/2/3 inserts 0/2/4/8 system clocks, with SCLK at idle level.
- R4: After select is released, it stays inactive for 4/6/8/12 system clocks (hold code 0/1/2/3). `done` is then high for exactly one cycle. `req_ready` stays low from acceptance through the done cycle.
- R5: SCLK idles low when `cfg_mode3`=0 and high when `cfg_mode3`=1. A request runs exactly `req_nclk` low-then-high pulses.
- R6: In mode 3 with `cfg_m3_inhibit`=0, one extra low phase of the low-time length follows the last high phase before select is released. With `cfg_m3_inhibit`=1, SCLK stays high as select is released.
- R7: `sample_stb` is high exactly `cfg_smpl_code` cycles after the first cycle of every high phase. `cap_data` holds the `sdio_in` value present in the strobe cycle, starting the following cycle.
- R8: A `pre_arm` pulse while idle drives `pre_dout`/`pre_oe` onto `sdio_out`/`sdio_oe` outside transactions. The drive is cleared at the next request acceptance and does not come back after that transaction.
- R9: With `bb_en`=1 (and enabled), `ss`, `sclk`, `sdio_out` and `sdio_oe` follow `bb_sel`, `bb_sclk`, `bb_dout` and `bb_oe` directly, and requests are refused. `bb_din` shows `sdio_in` one cycle later.
- R10: With `en`=0, select is inactive, SCLK is at idle level, all output enables are 0, and any running transaction is abandoned without a done pulse.
- R11: Timing configuration is captured at acceptance, so changes made during a transaction have no effect until it ends. A request with `req_nclk`=0 is ignored.
- R12: While select is asserted, `sdio_out`/`sdio_oe` carry `xfer_dout`/`xfer_oe`. Outside transactions they are 0 unless pre-select drive is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; 0 forces the idle state |
| cfg_mode3 | input | 1 | 0 = SPI mode 0, 1 = SPI mode 3 |
| cfg_hi_code | input | 4 | SCLK high time code (0 = 16) |
| cfg_lo_code | input | 4 | SCLK low time code (0 = 16) |
| cfg_setup_code | input | 2 | Select-to-clock setup code |
| cfg_hold_code | input | 2 | Select inactive hold code |
| cfg_smpl_code | input | 4 | Capture delay in system clocks |
| cfg_m3_inhibit | input | 1 | Suppress trailing mode-3 low pulse |
| cfg_sel_act_high | input | 1 | Select polarity, 1 = active high |
| req_valid | input | 1 | Transaction request |
| req_nclk | input | 8 | Number of SCLK pulses to run |
| req_ready | output | 1 | Engine can accept a request |
| done | output | 1 | One-cycle end-of-transaction pulse |
| pre_arm | input | 1 | Arm pre-select drive |
| pre_dout | input | 4 | Pre-select SDIO values |
| pre_oe | input | 4 | Pre-select SDIO output enables |
| bb_en | input | 1 | Bit-bang mode |
| bb_sel | input | 1 | Bit-bang select pin level |
| bb_sclk | input | 1 | Bit-bang SCLK level |
| bb_dout | input | 4 | Bit-bang SDIO values |
| bb_oe | input | 4 | Bit-bang SDIO output enables |
| xfer_dout | input | 4 | Data path SDIO values |
| xfer_oe | input | 4 | Data path SDIO output enables |
| sdio_in | input | 4 | SDIO pin input levels |
| sclk | output | 1 | Serial clock pin |
| ss | output | 1 | Slave select pin |
| sdio_out | output | 4 | SDIO output values |
| sdio_oe | output | 4 | SDIO output enables |
| sample_stb | output | 1 | Delayed capture strobe |
| cap_data | output | 4 | Captured input data |
| bb_din | output | 4 | Registered input levels for readback |

## Verification
Four transactions cover both modes and both trailing-edge options. They set phase codes at 1, at 16 (code 0) and at an odd large value, so a phase counter that is off by one or mishandles code 0 shows up as a shifted SCLK edge. All four setup and hold codes are used. Capture delays of 0, 2, 5 and 15 separate a strobe that is tied to the rising edge from one that follows phase boundaries. One run changes every configuration input right after acceptance, which exposes logic that reads the live settings. Further patterns cover zero-length requests, an abort by clearing the enable, pre-select drive and bit-bang mode, and show whether these override or block the engine as required.

// File: rtl/fss_pkg.sv
package fss_pkg;

  localparam int TMR_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_HOLD,
    ST_DONE
  } fss_state_e;

  typedef struct packed {
    logic       mode3;
    logic [3:0] hi_code;
    logic [3:0] lo_code;
    logic [1:0] setup_code;
    logic [1:0] hold_code;
    logic [3:0] smpl_code;
    logic       inhibit;
    logic       act_high;
  } fss_cfg_t;

  // SCLK phase length: code 0 stands for sixteen clocks
  function automatic logic [TMR_W-1:0] phase_len(input logic [3:0] code);
    return (code == 4'd0) ? TMR_W'(16) : TMR_W'(code);
  endfunction

  // select-to-clock setup: 0, 2, 4, 8
  function automatic logic [TMR_W-1:0] setup_len(input logic [1:0] code);
    case (code)
      2'd0:    return TMR_W'(0);
      2'd1:    return TMR_W'(2);
      2'd2:    return TMR_W'(4);
      default: return TMR_W'(8);
    endcase
  endfunction

  // inactive hold after release: 4, 6, 8, 12
  function automatic logic [TMR_W-1:0] hold_len(input logic [1:0] code);
    case (code)
      2'd0:    return TMR_W'(4);
      2'd1:    return TMR_W'(6);
      2'd2:    return TMR_W'(8);
      default: return TMR_W'(12);
    endcase
  endfunction

endpackage

// File: rtl/fss_phase_timer.sv
module fss_phase_timer #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= len - W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/fss_sample_delay.sv
module fss_sample_delay #(
  parameter int NCODES = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      rise,
  input  logic [$clog2(NCODES)-1:0] code,
  output logic                      stb
);

  localparam int SH_W = NCODES - 1;

  logic [SH_W-1:0]   shreg;
  logic [NCODES-1:0] taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (clr) begin
      shreg <= '0;
    end else begin
      shreg <= {shreg[SH_W-2:0], rise};
    end
  end

  assign taps = {shreg, rise};
  assign stb  = taps[code];

endmodule

// File: rtl/fss_pin_mux.sv
module fss_pin_mux #(
  parameter int IO_W = 4
) (
  input  logic            en,
  input  logic            live_mode3,
  input  logic            live_act_high,
  input  logic            bb_en,
  input  logic            bb_sel,
  input  logic            bb_sclk,
  input  logic [IO_W-1:0] bb_dout,
  input  logic [IO_W-1:0] bb_oe,
  input  logic            sel_active,
  input  logic            eng_sclk,
  input  logic            act_high_eff,
  input  logic            pre_armed,
  input  logic [IO_W-1:0] pre_dout_q,
  input  logic [IO_W-1:0] pre_oe_q,
  input  logic [IO_W-1:0] xfer_dout,
  input  logic [IO_W-1:0] xfer_oe,
  output logic            sclk,
  output logic            ss,
  output logic [IO_W-1:0] sdio_out,
  output logic [IO_W-1:0] sdio_oe
);

  always_comb begin
    if (!en) begin
      sclk     = live_mode3;
      ss       = ~live_act_high;
      sdio_out = '0;
      sdio_oe  = '0;
    end else if (bb_en) begin
      sclk     = bb_sclk;
      ss       = bb_sel;
      sdio_out = bb_dout;
      sdio_oe  = bb_oe;
    end else begin
      sclk = eng_sclk;
      ss   = act_high_eff ? sel_active : ~sel_active;
      if (sel_active) begin
        sdio_out = xfer_dout;
        sdio_oe  = xfer_oe;
      end else if (pre_armed) begin
        sdio_out = pre_dout_q;
        sdio_oe  = pre_oe_q;
      end else begin
        sdio_out = '0;
        sdio_oe  = '0;
      end
    end
  end

endmodule

// File: rtl/flash_sclk_sequencer.sv
module flash_sclk_sequencer
  import fss_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int IO_W   = 4,
  parameter int NCODES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             cfg_mode3,
  input  logic [3:0]       cfg_hi_code,
  input  logic [3:0]       cfg_lo_code,
  input  logic [1:0]       cfg_setup_code,
  input  logic [1:0]       cfg_hold_code,
  input  logic [3:0]       cfg_smpl_code,
  input  logic             cfg_m3_inhibit,
  input  logic             cfg_sel_act_high,
  input  logic             req_valid,
  input  logic [CNT_W-1:0] req_nclk,
  output logic             req_ready,
  output logic             done,
  input  logic             pre_arm,
  input  logic [IO_W-1:0]  pre_dout,
  input  logic [IO_W-1:0]  pre_oe,
  input  logic             bb_en,
  input  logic             bb_sel,
  input  logic             bb_sclk,
  input  logic [IO_W-1:0]  bb_dout,
  input  logic [IO_W-1:0]  bb_oe,
  input  logic [IO_W-1:0]  xfer_dout,
  input  logic [IO_W-1:0]  xfer_oe,
  input  logic [IO_W-1:0]  sdio_in,
  output logic             sclk,
  output logic             ss,
  output logic [IO_W-1:0]  sdio_out,
  output logic [IO_W-1:0]  sdio_oe,
  output logic             sample_stb,
  output logic [IO_W-1:0]  cap_data,
  output logic [IO_W-1:0]  bb_din
);

  fss_cfg_t         cfg_in, cfg_q;
  fss_state_e       state, state_n;
  logic [CNT_W-1:0] pulses_left;
  logic             tmr_load, tmr_expired;
  logic [TMR_W-1:0] tmr_len;
  logic             accept, busy, sel_active, eng_sclk, rise_evt, prev_high;
  logic             last_pulse, idle_lvl_mode3, act_high_eff;
  logic             pre_armed;
  logic [IO_W-1:0]  pre_dout_q, pre_oe_q;

  assign cfg_in = '{mode3: cfg_mode3, hi_code: cfg_hi_code, lo_code: cfg_lo_code,
                    setup_code: cfg_setup_code, hold_code: cfg_hold_code,
                    smpl_code: cfg_smpl_code, inhibit: cfg_m3_inhibit,
                    act_high: cfg_sel_act_high};

  assign req_ready  = (state == ST_IDLE) && en && !bb_en;
  assign accept     = req_ready && req_valid && (req_nclk != '0);
  assign busy       = (state != ST_IDLE);
  assign last_pulse = (pulses_left == CNT_W'(1));
  assign done       = (state == ST_DONE);

  // next-state and timer load selection
  always_comb begin
    state_n  = state;
    tmr_load = 1'b0;
    tmr_len  = '0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          tmr_load = 1'b1;
          if (setup_len(cfg_in.setup_code) != '0) begin
            state_n = ST_SETUP;
            tmr_len = setup_len(cfg_in.setup_code);
          end else begin
            state_n = ST_LOW;
            tmr_len = phase_len(cfg_in.lo_code);
          end
        end
      end
      ST_SETUP: begin
        if (tmr_expired) begin
          state_n  = ST_LOW;
          tmr_load = 1'b1;
          tmr_len  = phase_len(cfg_q.lo_code);
        end
      end
      ST_LOW: begin
        if (tmr_expired) begin
          state_n  = ST_HIGH;
          tmr_load = 1'b1;
          tmr_len  = phase_len(cfg_q.hi_code);
        end
      end
      ST_HIGH: begin
        if (tmr_expired) begin
          tmr_load = 1'b1;
          if (!last_pulse) begin
            state_n = ST_LOW;
            tmr_len = phase_len(cfg_q.lo_code);
          end else if (cfg_q.mode3 && !cfg_q.inhibit) begin
            state_n = ST_TAIL;
            tmr_len = phase_len(cfg_q.lo_code);
          end else begin
            state_n = ST_HOLD;
            tmr_len = hold_len(cfg_q.hold_code);
          end
        end
      end
      ST_TAIL: begin
        if (tmr_expired) begin
          state_n  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_len  = hold_len(cfg_q.hold_code);
        end
      end
      ST_HOLD: begin
        if (tmr_expired) state_n = ST_DONE;
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cfg_q       <= '0;
      pulses_left <= '0;
      prev_high   <= 1'b0;
    end else if (!en) begin
      state       <= ST_IDLE;
      pulses_left <= '0;
      prev_high   <= 1'b0;
    end else begin
      state     <= state_n;
      prev_high <= (state == ST_HIGH);
      if (accept) begin
        cfg_q       <= cfg_in;
        pulses_left <= req_nclk;
      end else if (state == ST_HIGH && tmr_expired && !last_pulse) begin
        pulses_left <= pulses_left - CNT_W'(1);
      end
    end
  end

  fss_phase_timer #(.W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!en),
    .load    (tmr_load),
    .len     (tmr_len),
    .expired (tmr_expired)
  );

  // engine-level pin intent
  assign sel_active = (state == ST_SETUP) || (state == ST_LOW) ||
                      (state == ST_HIGH)  || (state == ST_TAIL);
  assign idle_lvl_mode3 = (state == ST_IDLE) ? cfg_in.mode3 : cfg_q.mode3;
  assign act_high_eff   = (state == ST_IDLE) ? cfg_in.act_high : cfg_q.act_high;
  assign eng_sclk = (state == ST_HIGH) ||
                    (idle_lvl_mode3 && (state != ST_LOW) && (state != ST_TAIL));
  assign rise_evt = (state == ST_HIGH) && !prev_high;

  fss_sample_delay #(.NCODES(NCODES)) u_smpl (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!en),
    .rise  (rise_evt),
    .code  (cfg_q.smpl_code),
    .stb   (sample_stb)
  );

  // pre-select drive: armed while idle, dropped at acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_armed  <= 1'b0;
      pre_dout_q <= '0;
      pre_oe_q   <= '0;
    end else if (!en || accept) begin
      pre_armed <= 1'b0;
    end else if (pre_arm && state == ST_IDLE) begin
      pre_armed  <= 1'b1;
      pre_dout_q <= pre_dout;
      pre_oe_q   <= pre_oe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_data <= '0;
      bb_din   <= '0;
    end else begin
      bb_din <= sdio_in;
      if (sample_stb) cap_data <= sdio_in;
    end
  end

  fss_pin_mux #(.IO_W(IO_W)) u_pins (
    .en            (en),
    .live_mode3    (cfg_mode3),
    .live_act_high (cfg_sel_act_high),
    .bb_en         (bb_en),
    .bb_sel        (bb_sel),
    .bb_sclk       (bb_sclk),
    .bb_dout       (bb_dout),
    .bb_oe         (bb_oe),
    .sel_active    (sel_active),
    .eng_sclk      (eng_sclk),
    .act_high_eff  (act_high_eff),
    .pre_armed     (pre_armed),
    .pre_dout_q    (pre_dout_q),
    .pre_oe_q      (pre_oe_q),
    .xfer_dout     (xfer_dout),
    .xfer_oe       (xfer_oe),
    .sclk          (sclk),
    .ss            (ss),
    .sdio_out      (sdio_out),
    .sdio_oe       (sdio_oe)
  );

endmodule

// File: rtl/fss_checker.sv
module fss_checker (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic done,
  input logic req_ready,
  input logic accept,
  input logic busy,
  input logic sel_active,
  input logic eng_sclk,
  input logic rise_evt,
  input logic pre_armed,
  input logic cfg_q_mode3,
  input logic cfg_q_inhibit
);

  assert_done_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_sel_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sel_active);

  assert_accept_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_rise_in_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> (eng_sclk && sel_active));

  assert_pre_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !pre_armed);

  assert_disable_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  assert_inhibit_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sel_active) && $past(en) && cfg_q_mode3 && cfg_q_inhibit) |-> $past(eng_sclk));

  assert_tail_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sel_active) && $past(en) && cfg_q_mode3 && !cfg_q_inhibit) |-> !$past(eng_sclk));

endmodule

bind flash_sclk_sequencer fss_checker u_fss_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .en            (en),
  .done          (done),
  .req_ready     (req_ready),
  .accept        (accept),
  .busy          (busy),
  .sel_active    (sel_active),
  .eng_sclk      (eng_sclk),
  .rise_evt      (rise_evt),
  .pre_armed     (pre_armed),
  .cfg_q_mode3   (cfg_q.mode3),
  .cfg_q_inhibit (cfg_q.inhibit)
);

// File: tb/test_flash_sclk_sequencer.sv
module test_flash_sclk_sequencer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic cfg_mode3 = 1'b0, cfg_m3_inhibit = 1'b0, cfg_sel_act_high = 1'b0;
  logic [3:0] cfg_hi_code = 4'd1, cfg_lo_code = 4'd1, cfg_smpl_code = 4'd0;
  logic [1:0] cfg_setup_code = 2'd0, cfg_hold_code = 2'd0;
  logic req_valid = 1'b0;
  logic [7:0] req_nclk = 8'd0;
  logic req_ready, done;
  logic pre_arm = 1'b0;
  logic [3:0] pre_dout = 4'h0, pre_oe = 4'h0;
  logic bb_en = 1'b0, bb_sel = 1'b0, bb_sclk = 1'b0;
  logic [3:0] bb_dout = 4'h0, bb_oe = 4'h0;
  logic [3:0] xfer_dout = 4'hA, xfer_oe = 4'hF;
  logic [3:0] sdio_in = 4'h0;
  logic sclk, ss, sample_stb;
  logic [3:0] sdio_out, sdio_oe, cap_data, bb_din;

  int n_chk = 0;
  int n_err = 0;
  int din_ctr = 0;

  always #10 clk = ~clk;

  flash_sclk_sequencer i_flash_sclk_sequencer (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int b_phase(input int c); return (c == 0) ? 16 : c; endfunction
  function automatic int b_setup(input int c); return (c == 0) ? 0 : (1 << c); endfunction
  function automatic int b_hold(input int c);  return (c == 3) ? 12 : 4 + 2 * c; endfunction

  bit e_sel[1024];
  bit e_sclk[1024];
  bit e_done[1024];
  bit e_stb[1024];
  logic [3:0] din_hist[1024];

  task automatic run_xact(input int n, input bit chg);
    int len, lo, hi, dly;
    bit lm3, lact, linh;
    lm3 = cfg_mode3; lact = cfg_sel_act_high; linh = cfg_m3_inhibit;
    lo = b_phase(cfg_lo_code); hi = b_phase(cfg_hi_code); dly = cfg_smpl_code;
    for (int k = 0; k < 1024; k++) begin
      e_sel[k] = 0; e_sclk[k] = 0; e_done[k] = 0; e_stb[k] = 0;
    end
    len = 0;
    for (int k = 0; k < b_setup(cfg_setup_code); k++) begin
      e_sel[len] = 1; e_sclk[len] = lm3; len++;
    end
    for (int p = 0; p < n; p++) begin
      for (int k = 0; k < lo; k++) begin e_sel[len] = 1; e_sclk[len] = 0; len++; end
      e_stb[len + dly] = 1;
      for (int k = 0; k < hi; k++) begin e_sel[len] = 1; e_sclk[len] = 1; len++; end
    end
    if (lm3 && !linh)
      for (int k = 0; k < lo; k++) begin e_sel[len] = 1; e_sclk[len] = 0; len++; end
    for (int k = 0; k < b_hold(cfg_hold_code); k++) begin
      e_sel[len] = 0; e_sclk[len] = lm3; len++;
    end
    e_sel[len] = 0; e_sclk[len] = lm3; e_done[len] = 1; len++;

    @(negedge clk);
    req_valid = 1'b1; req_nclk = 8'(n);
    for (int i = 0; i < len + 20; i++) begin
      @(negedge clk);
      if (i < len) begin
        check(ss == (lact ? e_sel[i] : !e_sel[i]), "R1 ss", ss, lact ? e_sel[i] : !e_sel[i]);
        check(sclk == e_sclk[i], "R2/R3/R5/R6 sclk", sclk, e_sclk[i]);
        check(done == e_done[i], "R4 done", done, e_done[i]);
        check(req_ready == 1'b0, "R4 ready", req_ready, 0);
        check(sdio_oe == (e_sel[i] ? xfer_oe : 4'h0), "R12 oe", sdio_oe, e_sel[i] ? xfer_oe : 0);
        check(sdio_out == (e_sel[i] ? xfer_dout : 4'h0), "R12 out", sdio_out, e_sel[i] ? xfer_dout : 0);
      end else begin
        check(ss == !cfg_sel_act_high, "R1 idle ss", ss, !cfg_sel_act_high);
        check(sclk == cfg_mode3, "R5 idle sclk", sclk, cfg_mode3);
        check(done == 1'b0, "R4 done idle", done, 0);
        check(req_ready == 1'b1, "R4 ready idle", req_ready, 1);
      end
      check(sample_stb == e_stb[i], "R7 stb", sample_stb, e_stb[i]);
      if (i > 0 && e_stb[i-1])
        check(cap_data == din_hist[i-1], "R7 cap", cap_data, din_hist[i-1]);
      if (i == 0) begin
        req_valid = 1'b0;
        if (chg) begin  // R11: live settings change after acceptance
          cfg_hi_code = 4'd1; cfg_lo_code = 4'd1; cfg_setup_code = 2'd0;
          cfg_hold_code = 2'd0; cfg_smpl_code = 4'd0; cfg_mode3 = 1'b1;
          cfg_sel_act_high = 1'b1;
        end
      end
      din_ctr++;
      sdio_in = 4'(din_ctr) ^ 4'h5;
      din_hist[i] = sdio_in;
    end
  endtask

  task automatic set_cfg(input bit m3, input int hi, input int lo, input int su,
                         input int ho, input int d, input bit inh, input bit act);
    cfg_mode3 = m3; cfg_hi_code = 4'(hi); cfg_lo_code = 4'(lo);
    cfg_setup_code = 2'(su); cfg_hold_code = 2'(ho); cfg_smpl_code = 4'(d);
    cfg_m3_inhibit = inh; cfg_sel_act_high = act;
  endtask

  initial begin
    #(20 * 200000);
    check(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, R5 / R1 / R12
    check(ss == 1'b1, "R1 reset ss", ss, 1);
    check(sclk == 1'b0, "R5 reset sclk", sclk, 0);
    check(req_ready == 1'b1, "R4 reset ready", req_ready, 1);
    check(sdio_oe == 4'h0, "R12 reset oe", sdio_oe, 0);

    // mode 0, shortest phases
    set_cfg(0, 1, 1, 0, 0, 0, 0, 0);
    run_xact(3, 0);

    // R8: pre-select drive
    pre_dout = 4'h6; pre_oe = 4'h9; pre_arm = 1'b1;
    @(negedge clk);
    pre_arm = 1'b0;
    check(sdio_out == 4'h6, "R8 pre out", sdio_out, 6);
    check(sdio_oe == 4'h9, "R8 pre oe", sdio_oe, 9);

    // mode 3 with tail, 16-clock high, pre drive must vanish (R8)
    set_cfg(1, 0, 3, 3, 3, 5, 0, 0);
    run_xact(2, 0);
    check(sdio_oe == 4'h0, "R8 pre cleared", sdio_oe, 0);

    // mode 3 inhibit, active-high select, longest delay
    set_cfg(1, 2, 0, 1, 1, 15, 1, 1);
    run_xact(1, 0);

    // mode 0, large odd phases, config changed mid-run (R11)
    set_cfg(0, 15, 7, 2, 2, 2, 0, 0);
    run_xact(4, 1);
    set_cfg(0, 1, 1, 0, 0, 0, 0, 0);

    // R11: zero-length request ignored
    @(negedge clk);
    req_valid = 1'b1; req_nclk = 8'd0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(ss == 1'b1, "R11 zero ss", ss, 1);
      check(req_ready == 1'b1, "R11 zero ready", req_ready, 1);
    end
    req_valid = 1'b0;

    // R10: abort by clearing enable
    cfg_lo_code = 4'd8;
    req_valid = 1'b1; req_nclk = 8'd5;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(ss == 1'b0, "R10 pre-abort active", ss, 0);
    en = 1'b0;
    #1;
    check(ss == 1'b1, "R10 ss off", ss, 1);
    check(sclk == 1'b0, "R10 sclk idle", sclk, 0);
    check(sdio_oe == 4'h0, "R10 oe off", sdio_oe, 0);
    @(negedge clk);
    en = 1'b1;
    #1;
    check(req_ready == 1'b1, "R10 idle after abort", req_ready, 1);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(done == 1'b0, "R10 no done", done, 0);
      check(ss == 1'b1, "R10 stays idle", ss, 1);
    end
    cfg_lo_code = 4'd1;

    // R9: bit-bang
    bb_en = 1'b1; bb_sel = 1'b0; bb_sclk = 1'b1; bb_dout = 4'h3; bb_oe = 4'hC;
    sdio_in = 4'hB; req_valid = 1'b1; req_nclk = 8'd2;
    #1;
    check(ss == 1'b0, "R9 bb ss", ss, 0);
    check(sclk == 1'b1, "R9 bb sclk", sclk, 1);
    check(sdio_out == 4'h3, "R9 bb out", sdio_out, 3);
    check(sdio_oe == 4'hC, "R9 bb oe", sdio_oe, 12);
    check(req_ready == 1'b0, "R9 bb ready", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    check(bb_din == 4'hB, "R9 bb din", bb_din, 11);
    bb_en = 1'b0;
    #1;
    check(ss == 1'b1, "R9 request refused", ss, 1);
    check(req_ready == 1'b1, "R9 ready back", req_ready, 1);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule